// File: doc/BRIEF.md
# Triangle-Carrier Pulse-Width Modulator

This block is the pulse-width modulation slice of an instruction-driven execution unit. It watches the 32-bit instruction word. When the low five opcode bits select the modulation operation, it runs an internal up/down triangle carrier that rises from 0 to 255 and falls back to 0. On each cycle it compares that carrier with an 8-bit duty value taken from the instruction, and it drives a complementary pair of pulse outputs.

The two outputs are placed at fixed positions of a 28-bit result word, and every other result bit stays zero. The duty value is taken in only at the trough of the carrier, so a running pulse is never cut short. When any other opcode is present, the carrier parks at zero and both outputs go low.

Top module: `pwm_tri_gen`

## Requirements
- R1: The block is enabled only while instruction bits [4:0] equal 5'b11010. Any other opcode leaves both pulse outputs low, whatever the other instruction bits hold.
- R2: The duty value D is read from instruction bits [12:5], unsigned.
- R3: While enabled, the carrier steps by exactly one per clock. It rises 0,1,...,255, then falls 254,...,1, then rises again from 0. The full period is 510 clocks, and neither 0 nor 255 is held for two cycles.
- R4: Output A is high in a cycle exactly when D is greater than the carrier value. Over one carrier period, A is high for 2*D-1 cycles when D is at least 1.
- R5: While enabled, output B is the complement of output A in every cycle.
- R6: Output A sits at result bit 27 and output B at result bit 26. Result bits [25:0] are always zero.
- R7: D is captured only when the carrier is at 0. A duty change made in the middle of a period takes effect in the next period.
- R8: D = 0 keeps A low for the whole period. D = 255 makes A low for exactly one cycle per period, at the carrier peak.
- R9: One clock after the enable drops, both outputs are low and the carrier is back at 0. A later enable restarts the carrier from 0.
- R10: A synchronous active-high reset clears the result word and parks the carrier at 0.
- R11: The outputs are registered. The first result after the clock edge that sees the enable reflects carrier value 0, so A is high there exactly when D > 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word carrying the opcode and the duty field |
| res_o | output | 28 | Result word holding the pulse pair at bits 27 and 26 |

## Verification
The hardest case to reach from the ports is a duty change that lands while the carrier is away from zero. The change must be absorbed silently until the next trough. To reach it, the bench holds the enable, rewrites the duty field at a chosen point in the middle of a period, and counts the high cycles of output A separately over the first period and the second. The first count must match the old duty and the second the new one. The extremes 0 and 255 are run over whole periods, so the single low cycle at the peak and the absence of any pulse both show up in the counts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned OPC_W   = 5;
  localparam logic [OPC_W-1:0] OPC_PWM = 5'b11010;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/pwm_op_decode.sv
module pwm_op_decode #(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned OP_LSB   = 0,
  parameter int unsigned DUTY_LSB = 5,
  parameter int unsigned DUTY_W   = 8
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               hit,
  output logic [DUTY_W-1:0]  duty
);
  import pwm_pkg::*;

  assign hit  = (instr[OP_LSB +: OPC_W] == OPC_PWM);
  assign duty = instr[DUTY_LSB +: DUTY_W];
endmodule

// File: rtl/pwm_tri_carrier.sv
module pwm_tri_carrier #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] val,
  output logic          at_zero
);
  import pwm_pkg::*;

  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  sweep_dir_e dir_q;
  logic [CW-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      val_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (val_q == TOP) begin
        val_q <= TOP - ONE;
        dir_q <= DIR_DOWN;
      end else begin
        val_q <= val_q + ONE;
      end
    end else begin
      if (val_q == '0) begin
        val_q <= ONE;
        dir_q <= DIR_UP;
      end else begin
        val_q <= val_q - ONE;
      end
    end
  end

  assign val     = val_q;
  assign at_zero = (val_q == '0);
endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          at_zero,
  input  logic [DW-1:0] duty_in,
  output logic [DW-1:0] duty_held,
  output logic [DW-1:0] duty_eff
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (run && at_zero) begin
      held_q <= duty_in;
    end
  end

  assign duty_held = held_q;
  assign duty_eff  = at_zero ? duty_in : held_q;
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] duty,
  input  logic [DW-1:0] carrier,
  output logic          pa,
  output logic          pb
);
  logic above;
  assign above = (duty > carrier);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      pa <= above;
      pb <= ~above;
    end
  end
endmodule

// File: rtl/pwm_tri_gen.sv
module pwm_tri_gen #(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned RES_W    = 28,
  parameter int unsigned DUTY_W   = 8,
  parameter int unsigned OP_LSB   = 0,
  parameter int unsigned DUTY_LSB = 5,
  parameter int unsigned A_POS    = 27,
  parameter int unsigned B_POS    = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [RES_W-1:0]   res_o
);
  logic              op_hit;
  logic [DUTY_W-1:0] duty_in;
  logic [DUTY_W-1:0] car_val;
  logic              car_zero;
  logic [DUTY_W-1:0] duty_held;
  logic [DUTY_W-1:0] duty_eff;
  logic              pwm_a;
  logic              pwm_b;

  pwm_op_decode #(
    .INSTR_W(INSTR_W), .OP_LSB(OP_LSB), .DUTY_LSB(DUTY_LSB), .DUTY_W(DUTY_W)
  ) u_dec (
    .instr(instr_i), .hit(op_hit), .duty(duty_in)
  );

  pwm_tri_carrier #(.CW(DUTY_W)) u_car (
    .clk(clk), .rst(rst), .run(op_hit), .val(car_val), .at_zero(car_zero)
  );

  pwm_duty_hold #(.DW(DUTY_W)) u_hold (
    .clk(clk), .rst(rst), .run(op_hit), .at_zero(car_zero),
    .duty_in(duty_in), .duty_held(duty_held), .duty_eff(duty_eff)
  );

  pwm_out_stage #(.DW(DUTY_W)) u_out (
    .clk(clk), .rst(rst), .run(op_hit), .duty(duty_eff), .carrier(car_val),
    .pa(pwm_a), .pb(pwm_b)
  );

  always_comb begin
    res_o        = '0;
    res_o[A_POS] = pwm_a;
    res_o[B_POS] = pwm_b;
  end
endmodule

// File: rtl/pwm_tri_gen_chk.sv
module pwm_tri_gen_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] duty_q,
  input logic          pa,
  input logic          pb
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  // R3: carrier moves by exactly one step per enabled clock
  assert_carrier_step_R3: assert property (@(posedge clk) disable iff (rst)
    en |=> (cnt == DW'($past(cnt) + ONE) || cnt == DW'($past(cnt) - ONE)));

  // R9: disable parks the carrier and clears both outputs
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !pa && !pb));

  // R5: while enabled the pair is complementary
  assert_pair_complement_R5: assert property (@(posedge clk) disable iff (rst)
    en |=> (pa ^ pb));

  // R7: held duty never changes away from the trough
  assert_duty_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(duty_q));

  // R8: zero duty never produces a pulse
  assert_zero_duty_low_R8: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != '0 && duty_q == '0) |=> !pa);

  // R8: at the carrier peak output A is low
  assert_peak_low_R8: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == TOP) |=> !pa);
endmodule

bind pwm_tri_gen pwm_tri_gen_chk #(.DW(DUTY_W)) u_chk (
  .clk(clk), .rst(rst), .en(op_hit), .cnt(car_val), .duty_q(duty_held),
  .pa(pwm_a), .pb(pwm_b)
);

// File: tb/tb_pwm_tri_gen.sv
module tb_pwm_tri_gen;
  localparam int CLK_P = 10;
  localparam logic [4:0] OP_PWM = 5'b11010;
  localparam logic [4:0] OP_OTH = 5'b00101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [27:0] res;

  int n_run  = 0;
  int n_fail = 0;

  pwm_tri_gen dut (.clk(clk), .rst(rst), .instr_i(instr), .res_o(res));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [4:0] op, input logic [7:0] d);
    return {19'h7_1A2B, d, op};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    instr = mk(OP_OTH, 8'd77);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Runs n samples with PWM enabled, returns count of A high and complement errors
  task automatic sweep(input int n, output int hi, output int bad_pair, output int bad_rest);
    hi = 0; bad_pair = 0; bad_rest = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (res[27]) hi++;
      if (res[27] == res[26]) bad_pair++;
      if (res[25:0] != '0) bad_rest++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    instr = mk(OP_PWM, 8'd200);
    repeat (3) @(negedge clk);
    chk(res == '0, "R10 reset result", int'(res), 0);
    @(negedge clk);
    instr = mk(OP_OTH, 8'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_period(input logic [7:0] d);
    int hi, bp, br, exp_hi;
    go_idle();
    instr = mk(OP_PWM, d);
    @(negedge clk);
    chk(res[27] == (d > 0), "R11 first sample at carrier 0", res[27], int'(d > 0));
    chk(res[26] == (d == 0), "R5 first sample B", res[26], int'(d == 0));
    hi = int'(res[27]);
    begin
      int h2, bp2, br2;
      sweep(509, h2, bp2, br2);
      hi += h2; bp = bp2; br = br2;
    end
    exp_hi = (d == 0) ? 0 : 2 * int'(d) - 1;
    chk(hi == exp_hi, "R4 high count per period", hi, exp_hi);
    chk(bp == 0, "R5 complement errors", bp, 0);
    chk(br == 0, "R6 other result bits", br, 0);
  endtask

  task automatic t_extremes();
    int hi, bp, br;
    t_period(8'd0);
    go_idle();
    instr = mk(OP_PWM, 8'd255);
    sweep(255, hi, bp, br);
    chk(hi == 255, "R8 duty 255 rising half high", hi, 255);
    @(negedge clk);
    chk(res[27] == 1'b0, "R8 duty 255 low at peak", res[27], 0);
    chk(res[26] == 1'b1, "R8 duty 255 B high at peak", res[26], 1);
    sweep(254, hi, bp, br);
    chk(hi == 254, "R8 duty 255 falling half high", hi, 254);
  endtask

  task automatic t_shape();
    // Duty 128: A high for carrier 0..127 rising (samples 0..127), low 128..382, high 383..509
    int first_low, first_high_again;
    first_low = -1; first_high_again = -1;
    go_idle();
    instr = mk(OP_PWM, 8'd128);
    for (int k = 0; k < 510; k++) begin
      @(negedge clk);
      if (first_low < 0 && !res[27]) first_low = k;
      if (first_low >= 0 && first_high_again < 0 && res[27]) first_high_again = k;
    end
    chk(first_low == 128, "R3 rising ramp crossing", first_low, 128);
    chk(first_high_again == 383, "R3 falling ramp crossing", first_high_again, 383);
  endtask

  task automatic t_midchange();
    int hi, bp, br, h2;
    go_idle();
    instr = mk(OP_PWM, 8'd40);
    sweep(300, hi, bp, br);
    instr = mk(OP_PWM, 8'd200);
    sweep(210, h2, bp, br);
    hi += h2;
    chk(hi == 79, "R7 old duty kept for current period", hi, 79);
    sweep(510, hi, bp, br);
    chk(hi == 399, "R7 new duty in next period", hi, 399);
    chk(bp == 0, "R2 duty field pair intact", bp, 0);
  endtask

  task automatic t_other_op();
    int hi;
    hi = 0;
    go_idle();
    instr = mk(OP_OTH, 8'd255);
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (res != '0) hi++;
    end
    chk(hi == 0, "R1 other opcode gives no output", hi, 0);
    instr = mk(5'b11011, 8'd255);
    repeat (20) @(negedge clk);
    chk(res == '0, "R1 neighbouring opcode ignored", int'(res), 0);
  endtask

  task automatic t_disable();
    int hi, bp, br;
    go_idle();
    instr = mk(OP_PWM, 8'd10);
    sweep(100, hi, bp, br);
    instr = mk(OP_OTH, 8'd10);
    @(negedge clk);
    chk(res == '0, "R9 outputs low after disable", int'(res), 0);
    instr = mk(OP_PWM, 8'd10);
    sweep(510, hi, bp, br);
    chk(hi == 19, "R9 restart from carrier 0", hi, 19);
    @(negedge clk);
    chk(res[27] == 1'b1, "R9 next period starts high", res[27], 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_period(8'd1);
    t_period(8'd37);
    t_period(8'd254);
    t_extremes();
    t_shape();
    t_midchange();
    t_other_op();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule